// File: doc/BRIEF.md
# Single-Bit Hamming ECC Check and Repair

This block finishes the read path of a byte-oriented flash sector protected by a 24-bit Hamming-style code. A separate accumulator supplies a raw 32-bit parity word covering the sector just read. The block folds that word into a 24-bit code and inverts it, so that an erased sector (all data ones) produces the all-ones code that an erased spare area holds. The folded code can also be read out one byte at a time, which suits a write path that stores the code in the spare area.

On a one-cycle check strobe, the block compares the folded code with the 24-bit code read back from flash. The difference between the two sorts the sector into one of four cases: no error, one flipped data bit, one flipped bit inside the stored code only, or damage it cannot repair. For a data-bit error it reports the byte and the bit that are wrong. It also flips that bit in a local sector buffer, which software fills and drains through a simple byte port. The result is registered and appears one clock after the strobe.

Top module: `hecc_corrector`

## Requirements
- R1: The folded code is the bitwise inverse of {raw[27:16], raw[11:0]}. Raw bits 31:28 and 15:12 have no effect on it.
- R2: `code_byte_o` returns byte `code_sel_i` of the folded code, where byte 0 is bits 7:0, byte 1 is bits 15:8 and byte 2 is bits 23:16. Select value 3 returns 0.
- R3: `res_valid_o` is high for exactly one cycle, in the cycle after each cycle with `check_i` high, and is low otherwise.
- R4: When the folded code equals `stored_code_i`, the status is 0 (clean).
- R5: Let d = folded XOR stored. When d[23:12] XOR d[11:0] equals 12'hFFF and d[23:15] is below SECTOR_BYTES, the status is 1 (data corrected), the offset is d[23:15] and the bit is d[14:12].
- R6: When the halves of d are complementary but d[23:15] is not below SECTOR_BYTES, the status is 3 (uncorrectable).
- R7: When d has exactly one bit set, the status is 2 (error in stored code only), and no buffer byte changes.
- R8: Any other nonzero d gives status 3.
- R9: With status 1, the buffer byte at the offset is XORed with (1 << bit). The change is visible on the read port from the cycle in which `res_valid_o` is high.
- R10: Whenever the status is not 1, the offset and bit outputs read 0.
- R11: A write through the byte port stores `buf_wdata_i` at `buf_addr_i`. `buf_rdata_o` shows the byte at `buf_addr_i` without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_par_i | input | 32 | Raw parity word computed over the sector |
| code_sel_i | input | 2 | Byte select for the folded code |
| code_byte_o | output | 8 | Selected byte of the folded code |
| stored_code_i | input | 24 | Code read back from flash, byte 0 in bits 7:0 |
| check_i | input | 1 | Compare strobe |
| res_valid_o | output | 1 | Result valid, one cycle after the strobe |
| res_status_o | output | 2 | 0 clean, 1 corrected, 2 code only, 3 uncorrectable |
| res_offset_o | output | 9 | Byte offset of the flipped bit |
| res_bit_o | output | 3 | Bit index within that byte |
| buf_wr_i | input | 1 | Buffer write enable |
| buf_addr_i | input | ADDR_W | Buffer byte address |
| buf_wdata_i | input | 8 | Buffer write data |
| buf_rdata_o | output | 8 | Buffer read data |

## Verification
A fault in the fold or in the classifier shows up as a wrong status or location in the single cycle where `res_valid_o` is high. Because the result is registered, nothing carries the fault into later checks. A fault in the flip path is silent at the result outputs. It can only be seen by reading the buffer byte at the reported offset, and at a neighbouring offset for a code-only error, after the strobe. A second instance with a smaller sector exposes the range test, which can never fail at the default 512-byte size.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

  localparam int CODE_W  = 24;
  localparam int HALF_W  = 12;
  localparam int RAW_W   = 32;
  localparam int OFF_W   = 9;
  localparam int BIT_W   = 3;
  localparam int BYTE_W  = 8;
  localparam int NBYTES  = CODE_W / BYTE_W;

  typedef enum logic [1:0] {
    ST_CLEAN     = 2'd0,
    ST_FIXED     = 2'd1,
    ST_CODE_ONLY = 2'd2,
    ST_BAD       = 2'd3
  } ecc_status_e;

  // Fold the raw parity word into the 24-bit code, inverted so an erased sector matches.
  function automatic logic [CODE_W-1:0] fold_raw(input logic [RAW_W-1:0] raw);
    return ~{raw[27:16], raw[11:0]};
  endfunction

  // True when the two halves of the difference are exact complements.
  function automatic logic halves_complement(input logic [CODE_W-1:0] d);
    return (d[CODE_W-1:HALF_W] ^ d[HALF_W-1:0]) == {HALF_W{1'b1}};
  endfunction

  // True when exactly one bit of the difference is set.
  function automatic logic lone_bit(input logic [CODE_W-1:0] d);
    return (d != '0) && ((d & (d - 1'b1)) == '0);
  endfunction

endpackage

// File: rtl/hecc_code_pack.sv
module hecc_code_pack
  import hecc_pkg::*;
(
  input  logic [RAW_W-1:0]  raw_i,
  input  logic [1:0]        sel_i,
  output logic [CODE_W-1:0] code_o,
  output logic [BYTE_W-1:0] byte_o
);

  logic [BYTE_W-1:0] lanes [NBYTES];

  assign code_o = fold_raw(raw_i);

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lanes[g] = code_o[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    byte_o = '0;
    for (int k = 0; k < NBYTES; k++) begin
      if (int'(sel_i) == k) byte_o = lanes[k];
    end
  end

endmodule

// File: rtl/hecc_classifier.sv
module hecc_classifier
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              check_i,
  input  logic [CODE_W-1:0] calc_i,
  input  logic [CODE_W-1:0] stored_i,
  output logic              valid_o,
  output logic [1:0]        status_o,
  output logic [OFF_W-1:0]  offset_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              fix_fire_o,
  output logic [OFF_W-1:0]  fix_off_o,
  output logic [BYTE_W-1:0] fix_mask_o
);

  logic [CODE_W-1:0] diff;
  logic [OFF_W-1:0]  cand_off;
  logic [BIT_W-1:0]  cand_bit;
  logic              in_range;
  ecc_status_e       cls;

  assign diff     = calc_i ^ stored_i;
  assign cand_off = diff[CODE_W-1 -: OFF_W];
  assign cand_bit = diff[HALF_W +: BIT_W];
  assign in_range = int'(cand_off) < SECTOR_BYTES;

  always_comb begin
    if (diff == '0)                             cls = ST_CLEAN;
    else if (halves_complement(diff) && in_range) cls = ST_FIXED;
    else if (halves_complement(diff))           cls = ST_BAD;
    else if (lone_bit(diff))                    cls = ST_CODE_ONLY;
    else                                        cls = ST_BAD;
  end

  assign fix_fire_o = check_i && (cls == ST_FIXED);
  assign fix_off_o  = cand_off;
  assign fix_mask_o = BYTE_W'(1) << cand_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      status_o <= ST_CLEAN;
      offset_o <= '0;
      bit_o    <= '0;
    end else begin
      valid_o <= check_i;
      if (check_i) begin
        status_o <= cls;
        offset_o <= (cls == ST_FIXED) ? cand_off : '0;
        bit_o    <= (cls == ST_FIXED) ? cand_bit : '0;
      end
    end
  end

endmodule

// File: rtl/hecc_sector_buf.sv
module hecc_sector_buf
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int ADDR_W = (SECTOR_BYTES > 1) ? $clog2(SECTOR_BYTES) : 1
) (
  input  logic              clk,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              fix_i,
  input  logic [OFF_W-1:0]  fix_off_i,
  input  logic [BYTE_W-1:0] fix_mask_i
);

  logic [BYTE_W-1:0] mem [SECTOR_BYTES];
  logic [ADDR_W-1:0] fix_addr;

  assign fix_addr = fix_off_i[ADDR_W-1:0];
  assign rdata_o  = mem[addr_i];

  // The flip is written last, so it takes priority on an address clash.
  always_ff @(posedge clk) begin
    if (wr_i) mem[addr_i] <= wdata_i;
    if (fix_i) mem[fix_addr] <= mem[fix_addr] ^ fix_mask_i;
  end

endmodule

// File: rtl/hecc_corrector.sv
module hecc_corrector
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int ADDR_W = (SECTOR_BYTES > 1) ? $clog2(SECTOR_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       raw_par_i,
  input  logic [1:0]        code_sel_i,
  output logic [7:0]        code_byte_o,
  input  logic [23:0]       stored_code_i,
  input  logic              check_i,
  output logic              res_valid_o,
  output logic [1:0]        res_status_o,
  output logic [8:0]        res_offset_o,
  output logic [2:0]        res_bit_o,
  input  logic              buf_wr_i,
  input  logic [ADDR_W-1:0] buf_addr_i,
  input  logic [7:0]        buf_wdata_i,
  output logic [7:0]        buf_rdata_o
);

  logic [CODE_W-1:0] calc_code;
  logic              fix_fire;
  logic [OFF_W-1:0]  fix_off;
  logic [BYTE_W-1:0] fix_mask;

  hecc_code_pack u_pack (
    .raw_i  (raw_par_i),
    .sel_i  (code_sel_i),
    .code_o (calc_code),
    .byte_o (code_byte_o)
  );

  hecc_classifier #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
    .clk        (clk),
    .rst_n      (rst_n),
    .check_i    (check_i),
    .calc_i     (calc_code),
    .stored_i   (stored_code_i),
    .valid_o    (res_valid_o),
    .status_o   (res_status_o),
    .offset_o   (res_offset_o),
    .bit_o      (res_bit_o),
    .fix_fire_o (fix_fire),
    .fix_off_o  (fix_off),
    .fix_mask_o (fix_mask)
  );

  hecc_sector_buf #(.SECTOR_BYTES(SECTOR_BYTES)) u_buf (
    .clk        (clk),
    .wr_i       (buf_wr_i),
    .addr_i     (buf_addr_i),
    .wdata_i    (buf_wdata_i),
    .rdata_o    (buf_rdata_o),
    .fix_i      (fix_fire),
    .fix_off_i  (fix_off),
    .fix_mask_i (fix_mask)
  );

endmodule

// File: rtl/hecc_corrector_chk.sv
module hecc_corrector_chk #(
  parameter int SECTOR_BYTES = 512
) (
  input logic       clk,
  input logic       rst_n,
  input logic       check_i,
  input logic       res_valid_o,
  input logic [1:0] res_status_o,
  input logic [8:0] res_offset_o,
  input logic [2:0] res_bit_o,
  input logic       fix_fire
);

  // R3
  valid_follows_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
    check_i |=> res_valid_o);

  // R3
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !check_i |=> !res_valid_o);

  // R6
  fixed_offset_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_status_o == 2'd1) |-> (int'(res_offset_o) < SECTOR_BYTES));

  // R10
  idle_location_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_status_o != 2'd1) |-> (res_offset_o == '0 && res_bit_o == '0));

  // R9
  fix_reported_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix_fire |=> (res_valid_o && res_status_o == 2'd1));

endmodule

bind hecc_corrector hecc_corrector_chk #(.SECTOR_BYTES(SECTOR_BYTES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .check_i      (check_i),
  .res_valid_o  (res_valid_o),
  .res_status_o (res_status_o),
  .res_offset_o (res_offset_o),
  .res_bit_o    (res_bit_o),
  .fix_fire     (fix_fire)
);

// File: tb/hecc_corrector_tb_top.sv
`timescale 1ns/1ps
module hecc_corrector_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] raw_par_i = '0;
  logic [1:0]  code_sel_i = '0;
  logic [7:0]  code_byte_o;
  logic [23:0] stored_code_i = '0;
  logic        check_i = 1'b0;
  logic        res_valid_o;
  logic [1:0]  res_status_o;
  logic [8:0]  res_offset_o;
  logic [2:0]  res_bit_o;
  logic        buf_wr_i = 1'b0;
  logic [8:0]  buf_addr_i = '0;
  logic [7:0]  buf_wdata_i = '0;
  logic [7:0]  buf_rdata_o;

  logic [7:0]  s_code_byte;
  logic        s_valid;
  logic [1:0]  s_status;
  logic [8:0]  s_offset;
  logic [2:0]  s_bit;
  logic [7:0]  s_rdata;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  hecc_corrector dut_i (
    .clk(clk), .rst_n(rst_n), .raw_par_i(raw_par_i), .code_sel_i(code_sel_i),
    .code_byte_o(code_byte_o), .stored_code_i(stored_code_i), .check_i(check_i),
    .res_valid_o(res_valid_o), .res_status_o(res_status_o), .res_offset_o(res_offset_o),
    .res_bit_o(res_bit_o), .buf_wr_i(buf_wr_i), .buf_addr_i(buf_addr_i),
    .buf_wdata_i(buf_wdata_i), .buf_rdata_o(buf_rdata_o)
  );

  // Smaller sector, used to exercise the range test.
  hecc_corrector #(.SECTOR_BYTES(256)) dut_s_i (
    .clk(clk), .rst_n(rst_n), .raw_par_i(raw_par_i), .code_sel_i(code_sel_i),
    .code_byte_o(s_code_byte), .stored_code_i(stored_code_i), .check_i(check_i),
    .res_valid_o(s_valid), .res_status_o(s_status), .res_offset_o(s_offset),
    .res_bit_o(s_bit), .buf_wr_i(buf_wr_i), .buf_addr_i(buf_addr_i[7:0]),
    .buf_wdata_i(buf_wdata_i), .buf_rdata_o(s_rdata)
  );

  typedef struct {
    logic [1:0] st;
    logic [8:0] off;
    logic [2:0] bt;
    logic [1:0] st_small;
    string      req;
  } exp_t;

  exp_t sb[$];

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Independent reference model of the classification.
  function automatic exp_t model(input logic [31:0] raw, input logic [23:0] stored,
                                 input int sector, input string req);
    exp_t e;
    logic [23:0] calc, d;
    logic [11:0] hi, lo;
    int ones;
    calc = 24'((((raw & 32'h0FFF_0000) >> 4) | (raw & 32'h0000_0FFF))) ^ 24'hFF_FFFF;
    d    = calc ^ stored;
    hi   = d[23:12];
    lo   = d[11:0];
    ones = $countones(d);
    e.off = '0; e.bt = '0; e.req = req;
    if (ones == 0) e.st = 2'd0;
    else if ((hi ^ lo) == 12'hFFF) begin
      if ((hi >> 3) < sector) begin
        e.st = 2'd1; e.off = 9'(hi >> 3); e.bt = hi[2:0];
      end else e.st = 2'd3;
    end else if (ones == 1) e.st = 2'd2;
    else e.st = 2'd3;
    return e;
  endfunction

  function automatic logic [31:0] raw_for(input logic [23:0] code);
    return {4'hA, ~code[23:12], 4'h5, ~code[11:0]};
  endfunction

  function automatic logic [23:0] flip_diff(input int off, input int bt);
    logic [11:0] hi;
    hi = {9'(off), 3'(bt)};
    return {hi, ~hi};
  endfunction

  task automatic run_check(input logic [31:0] raw, input logic [23:0] stored, input string req);
    exp_t e, es;
    e  = model(raw, stored, 512, req);
    es = model(raw, stored, 256, req);
    e.st_small = es.st;
    @(negedge clk);
    raw_par_i = raw; stored_code_i = stored; check_i = 1'b1;
    sb.push_back(e);
    @(negedge clk);
    check_i = 1'b0;
  endtask

  task automatic buf_put(input int a, input logic [7:0] v);
    @(negedge clk);
    buf_addr_i = 9'(a); buf_wdata_i = v; buf_wr_i = 1'b1;
    @(negedge clk);
    buf_wr_i = 1'b0;
  endtask

  task automatic buf_expect(input int a, input logic [7:0] v, input string req);
    @(negedge clk);
    buf_addr_i = 9'(a);
    #1;
    chk(buf_rdata_o == v, req, buf_rdata_o, v);
  endtask

  // Monitor: pops the scoreboard on every valid result.
  always @(negedge clk) begin
    if (rst_n && res_valid_o) begin
      if (sb.size() == 0) chk(1'b0, "R3 unexpected valid", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(res_status_o == e.st, {e.req, " status"}, res_status_o, e.st);
        chk(res_offset_o == e.off, {e.req, " offset R10"}, res_offset_o, e.off);
        chk(res_bit_o == e.bt, {e.req, " bit R10"}, res_bit_o, e.bt);
        chk(s_status == e.st_small, {e.req, " small-sector status R6"}, s_status, e.st_small);
      end
    end
  end

  logic [23:0] base_code = 24'h3C5A96;
  logic        done = 1'b0;

  initial begin
    #(200000 * 20);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(res_valid_o == 1'b0, "reset R3 valid", res_valid_o, 0);
    chk(res_status_o == 2'd0, "reset status", res_status_o, 0);
    rst_n = 1'b1;

    // R1 and R2: fold, inversion, ignored raw bits, byte order
    raw_par_i = raw_for(base_code);
    for (int s = 0; s < 4; s++) begin
      logic [7:0] eb;
      @(negedge clk);
      code_sel_i = 2'(s);
      #1;
      eb = (s == 3) ? 8'h00 : base_code[8*s +: 8];
      chk(code_byte_o == eb, "R1 R2 code byte", code_byte_o, eb);
    end
    raw_par_i = 32'h0000_0000;
    @(negedge clk); code_sel_i = 2'd2; #1;
    chk(code_byte_o == 8'hFF, "R1 erased inversion", code_byte_o, 8'hFF);
    raw_par_i = 32'hF000_F000;
    #1;
    chk(code_byte_o == 8'hFF, "R1 ignored raw bits", code_byte_o, 8'hFF);

    // R4: erased sector and a matching nonzero code
    run_check(32'h0000_0000, 24'hFF_FFFF, "R4 erased clean");
    run_check(raw_for(base_code), base_code, "R4 match clean");

    // R11 buffer fill, then R5/R9 corrections
    buf_put(37, 8'h00);
    buf_put(300, 8'hF0);
    buf_put(511, 8'hAA);
    buf_put(0, 8'h01);
    buf_put(36, 8'h5C);
    buf_expect(36, 8'h5C, "R11 write/read");

    run_check(raw_for(base_code), base_code ^ flip_diff(37, 4), "R5 offset 37 bit 4");
    buf_expect(37, 8'h10, "R9 flip at 37");
    run_check(raw_for(base_code), base_code ^ flip_diff(300, 2), "R5 R6 offset 300");
    buf_expect(300, 8'hF4, "R9 flip at 300");
    run_check(raw_for(24'h000000), 24'h000000 ^ flip_diff(511, 7), "R5 R6 offset 511 bit 7");
    buf_expect(511, 8'h2A, "R9 flip at 511");
    run_check(raw_for(24'h123456), 24'h123456 ^ flip_diff(0, 0), "R5 offset 0 bit 0");
    buf_expect(0, 8'h00, "R9 flip at 0");

    // R7: code-only error leaves the buffer untouched
    run_check(raw_for(base_code), base_code ^ 24'h000800, "R7 code-only bit 11");
    buf_expect(37, 8'h10, "R7 buffer unchanged at 37");
    buf_expect(36, 8'h5C, "R7 buffer unchanged at 36");
    run_check(raw_for(base_code), base_code ^ 24'h800000, "R7 code-only bit 23");

    // R8: other multi-bit differences
    run_check(raw_for(base_code), base_code ^ 24'h000003, "R8 two bits");
    run_check(raw_for(base_code), base_code ^ 24'h800001, "R8 spread bits");
    buf_expect(37, 8'h10, "R8 buffer unchanged");

    // R3: back-to-back strobes
    @(negedge clk);
    raw_par_i = raw_for(base_code); stored_code_i = base_code; check_i = 1'b1;
    begin
      exp_t e, es;
      e = model(raw_par_i, stored_code_i, 512, "R3 burst first");
      es = model(raw_par_i, stored_code_i, 256, "R3 burst first");
      e.st_small = es.st; sb.push_back(e);
    end
    @(negedge clk);
    stored_code_i = base_code ^ 24'h000010;
    begin
      exp_t e, es;
      e = model(raw_par_i, stored_code_i, 512, "R3 burst second");
      es = model(raw_par_i, stored_code_i, 256, "R3 burst second");
      e.st_small = es.st; sb.push_back(e);
    end
    @(negedge clk);
    check_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R3 all results seen", sb.size(), 0);
    chk(res_valid_o == 1'b0, "R3 valid drops", res_valid_o, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule